// File: doc/BRIEF.md
# Edge Event Blanking Window Filter

This block turns a raw external trip-style input into a single-clock event on each rising edge, after bringing the input into the local clock domain through a flop synchroniser. That event is then passed or suppressed by a programmable blanking window. The window is positioned from every counter-zero strobe that the PWM timebase produces: it opens a programmable number of clocks after the strobe and stays open for a programmable number of clocks.

In normal mode an event that lands inside the window is dropped and one outside it passes. In inverted mode only events inside the window pass. A select picks whether the sync event sent back to a timebase comes from the unfiltered or the filtered event. In a typical use, a first zero-crossing edge re-phases the timebase. A spurious second edge arriving a fixed time later is then removed by a window placed over that time.

Top module: `edge_blank_filter`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `rawEvt`, `filtEvt` and `syncEvt` are 0, and the window is closed.
- R2: With the default two synchroniser stages, if `trigIn` goes from 0 to 1 before clock edge k, `rawEvt` is 1 in the cycle between edges k+1 and k+2 and is 0 in the cycles just before and after it.
- R3: `rawEvt` is exactly one cycle wide however long `trigIn` stays high, and a falling edge of `trigIn` produces no event.
- R4: Count the cycle after the edge that samples `zeroStrobe` high as n = 0. The window is open in cycles n = `cfgOffset` to `cfgOffset` + `cfgWidth` - 1 and closed in every other cycle.
- R5: With `cfgBlankEn` = 1 and `cfgInvert` = 0, an event in an open-window cycle gives `filtEvt` = 0, and an event in a closed-window cycle gives `filtEvt` = 1.
- R6: With `cfgBlankEn` = 1 and `cfgInvert` = 1, `filtEvt` is 1 only for events in open-window cycles.
- R7: With `cfgBlankEn` = 0, `filtEvt` equals `rawEvt` in every cycle, whatever the window state.
- R8: `syncEvt` equals `filtEvt` when `cfgSyncFilt` = 1 and equals `rawEvt` when `cfgSyncFilt` = 0.
- R9: A `zeroStrobe` that arrives while the offset or width count is running restarts the offset count from that strobe.
- R10: With `cfgWidth` = 0 the window never opens: inverted mode then passes no event, and normal mode passes every event.
- R11: `filtEvt` is never 1 in a cycle where `rawEvt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Raw asynchronous trip-style input |
| zeroStrobe | input | 1 | One-cycle strobe when the timebase counter reaches zero |
| cfgOffset | input | CNT_W (16) | Clocks from the zero strobe to window opening |
| cfgWidth | input | CNT_W (16) | Window length in clocks |
| cfgInvert | input | 1 | 1: pass only inside the window; 0: blank inside the window |
| cfgBlankEn | input | 1 | 1: apply the window; 0: filtered event follows raw event |
| cfgSyncFilt | input | 1 | 1: sync from the filtered event; 0: sync from the raw event |
| rawEvt | output | 1 | One-cycle event per qualified rising edge |
| filtEvt | output | 1 | Event after blanking |
| syncEvt | output | 1 | Selected event for timebase re-phasing |

## Verification
The window state cannot be seen at the ports. Its edges can only be inferred by placing an input edge so that the synchronised event lands in a chosen cycle relative to a zero strobe. The bench therefore raises `trigIn` a computed number of clocks after the strobe, allowing for the two synchroniser stages and the edge register. This puts each event on the cycle just before, the first, the last and the one after the open window. The restart case is the hardest to reach. A second strobe is issued mid-offset, and an event is placed where the first window would have been open but the restarted one is still closed, so only the restart explains the result.

// File: rtl/edge_blank_pkg.sv
package edge_blank_pkg;

  // Phase of the blanking-window sequencer
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_OFFSET = 2'd1,
    PH_WINDOW = 2'd2
  } winPhase_e;

  // Strobes passed from the window control to the event datapath
  typedef struct packed {
    logic windowOpen;   // current cycle lies inside the window
    logic offsetRun;    // offset count in progress
  } winCtl_t;

endpackage

// File: rtl/edge_blank_ctrl.sv
module edge_blank_ctrl
  import edge_blank_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             zeroStrobe,
  input  logic [CNT_W-1:0] cfgOffset,
  input  logic [CNT_W-1:0] cfgWidth,
  output winCtl_t          winCtl
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  winPhase_e        phase, phaseNxt;
  logic [CNT_W-1:0] cnt, cntNxt;

  logic offsetZero, widthZero, offsetDone, widthDone;

  assign offsetZero = (cfgOffset == CNT_ZERO);
  assign widthZero  = (cfgWidth == CNT_ZERO);
  assign offsetDone = (cnt == (cfgOffset - CNT_ONE));
  assign widthDone  = (cnt == (cfgWidth - CNT_ONE));

  always_comb begin
    phaseNxt = phase;
    cntNxt   = cnt;
    if (zeroStrobe) begin
      // every strobe restarts the sequence from its own reference point
      cntNxt = CNT_ZERO;
      if (!offsetZero)     phaseNxt = PH_OFFSET;
      else if (!widthZero) phaseNxt = PH_WINDOW;
      else                 phaseNxt = PH_IDLE;
    end else begin
      unique case (phase)
        PH_OFFSET: begin
          if (offsetDone) begin
            cntNxt   = CNT_ZERO;
            phaseNxt = widthZero ? PH_IDLE : PH_WINDOW;
          end else begin
            cntNxt = cnt + CNT_ONE;
          end
        end
        PH_WINDOW: begin
          if (widthDone) begin
            cntNxt   = CNT_ZERO;
            phaseNxt = PH_IDLE;
          end else begin
            cntNxt = cnt + CNT_ONE;
          end
        end
        default: begin
          cntNxt   = CNT_ZERO;
          phaseNxt = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= CNT_ZERO;
    end else begin
      phase <= phaseNxt;
      cnt   <= cntNxt;
    end
  end

  assign winCtl.windowOpen = (phase == PH_WINDOW);
  assign winCtl.offsetRun  = (phase == PH_OFFSET);

endmodule

// File: rtl/edge_blank_dpath.sv
module edge_blank_dpath
  import edge_blank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    trigIn,
  input  winCtl_t winCtl,
  input  logic    cfgInvert,
  input  logic    cfgBlankEn,
  input  logic    cfgSyncFilt,
  output logic    rawEvt,
  output logic    filtEvt,
  output logic    syncEvt
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncChain;
  logic          levelPrev;
  logic          passEvt;

  // flop synchroniser, depth chosen by parameter
  generate
    for (genvar s = 0; s <= LAST; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= trigIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[s] <= 1'b0;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) levelPrev <= 1'b0;
    else       levelPrev <= syncChain[LAST];
  end

  // rising edge qualified by the new high level
  assign rawEvt = syncChain[LAST] & ~levelPrev;

  always_comb begin
    if (cfgInvert) passEvt = rawEvt &  winCtl.windowOpen;
    else           passEvt = rawEvt & ~winCtl.windowOpen;
  end

  assign filtEvt = cfgBlankEn  ? passEvt : rawEvt;
  assign syncEvt = cfgSyncFilt ? filtEvt : rawEvt;

endmodule

// File: rtl/edge_blank_filter.sv
module edge_blank_filter
  import edge_blank_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic             zeroStrobe,
  input  logic [CNT_W-1:0] cfgOffset,
  input  logic [CNT_W-1:0] cfgWidth,
  input  logic             cfgInvert,
  input  logic             cfgBlankEn,
  input  logic             cfgSyncFilt,
  output logic             rawEvt,
  output logic             filtEvt,
  output logic             syncEvt
);

  winCtl_t winCtl;

  edge_blank_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .zeroStrobe (zeroStrobe),
    .cfgOffset  (cfgOffset),
    .cfgWidth   (cfgWidth),
    .winCtl     (winCtl)
  );

  edge_blank_dpath #(.SYNC_STAGES(SYNC_STAGES)) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .trigIn      (trigIn),
    .winCtl      (winCtl),
    .cfgInvert   (cfgInvert),
    .cfgBlankEn  (cfgBlankEn),
    .cfgSyncFilt (cfgSyncFilt),
    .rawEvt      (rawEvt),
    .filtEvt     (filtEvt),
    .syncEvt     (syncEvt)
  );

endmodule

// File: rtl/edge_blank_filter_chk.sv
module edge_blank_filter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             zeroStrobe,
  input logic [CNT_W-1:0] cfgOffset,
  input logic [CNT_W-1:0] cfgWidth,
  input logic             cfgBlankEn,
  input logic             cfgSyncFilt,
  input logic             rawEvt,
  input logic             filtEvt,
  input logic             syncEvt,
  input logic             winOpen
);

  // R3: an event never lasts two cycles
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rawEvt |=> !rawEvt);

  // R11: the filter can only remove events
  a_r11_filter_subset: assert property (@(posedge clk) disable iff (!rstN)
    filtEvt |-> rawEvt);

  // R7: blanking disabled
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rstN)
    !cfgBlankEn |-> (filtEvt == rawEvt));

  // R8: sync source selection
  a_r8_sync_filt: assert property (@(posedge clk) disable iff (!rstN)
    cfgSyncFilt |-> (syncEvt == filtEvt));
  a_r8_sync_raw: assert property (@(posedge clk) disable iff (!rstN)
    !cfgSyncFilt |-> (syncEvt == rawEvt));

  // R4 and R9: a strobe with non-zero offset closes the window next cycle
  a_r4_strobe_closes: assert property (@(posedge clk) disable iff (!rstN)
    (zeroStrobe && cfgOffset != '0) |=> !winOpen);

  // R4: zero offset and non-zero width opens the window next cycle
  a_r4_zero_offset_opens: assert property (@(posedge clk) disable iff (!rstN)
    (zeroStrobe && cfgOffset == '0 && cfgWidth != '0) |=> winOpen);

  // R10: zero width with zero offset keeps the window shut
  a_r10_zero_width: assert property (@(posedge clk) disable iff (!rstN)
    (zeroStrobe && cfgOffset == '0 && cfgWidth == '0) |=> !winOpen);

endmodule

bind edge_blank_filter edge_blank_filter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .zeroStrobe  (zeroStrobe),
  .cfgOffset   (cfgOffset),
  .cfgWidth    (cfgWidth),
  .cfgBlankEn  (cfgBlankEn),
  .cfgSyncFilt (cfgSyncFilt),
  .rawEvt      (rawEvt),
  .filtEvt     (filtEvt),
  .syncEvt     (syncEvt),
  .winOpen     (winCtl.windowOpen)
);

// File: tb/edge_blank_filter_tb_top.sv
module edge_blank_filter_tb_top;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             trigIn = 1'b0;
  logic             zeroStrobe = 1'b0;
  logic [CNT_W-1:0] cfgOffset = '0;
  logic [CNT_W-1:0] cfgWidth = '0;
  logic             cfgInvert = 1'b0;
  logic             cfgBlankEn = 1'b0;
  logic             cfgSyncFilt = 1'b0;
  logic             rawEvt, filtEvt, syncEvt;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycCnt   = 0;

  always #4 clk = ~clk;   // 125 MHz

  edge_blank_filter #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .zeroStrobe(zeroStrobe),
    .cfgOffset(cfgOffset), .cfgWidth(cfgWidth), .cfgInvert(cfgInvert),
    .cfgBlankEn(cfgBlankEn), .cfgSyncFilt(cfgSyncFilt),
    .rawEvt(rawEvt), .filtEvt(filtEvt), .syncEvt(syncEvt)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
  endtask

  always @(posedge clk) begin
    cycCnt++;
    if (cycCnt == 100000) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  // offset, width, invert, blankEn, syncFilt, n (event cycle), expFilt, expSync
  typedef struct packed {
    logic [15:0] off;
    logic [15:0] wid;
    logic        inv;
    logic        en;
    logic        src;
    logic [7:0]  n;
    logic        eFilt;
    logic        eSync;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{16'd4, 16'd3, 1'b0, 1'b1, 1'b1, 8'd3, 1'b1, 1'b1},  // R5 before window
    '{16'd4, 16'd3, 1'b0, 1'b1, 1'b1, 8'd4, 1'b0, 1'b0},  // R4/R5 first open cycle
    '{16'd4, 16'd3, 1'b0, 1'b1, 1'b1, 8'd6, 1'b0, 1'b0},  // R4/R5 last open cycle
    '{16'd4, 16'd3, 1'b0, 1'b1, 1'b1, 8'd7, 1'b1, 1'b1},  // R4/R5 after window
    '{16'd4, 16'd3, 1'b1, 1'b1, 1'b1, 8'd3, 1'b0, 1'b0},  // R6 before window
    '{16'd4, 16'd3, 1'b1, 1'b1, 1'b1, 8'd4, 1'b1, 1'b1},  // R6 first open cycle
    '{16'd4, 16'd3, 1'b1, 1'b1, 1'b1, 8'd6, 1'b1, 1'b1},  // R6 last open cycle
    '{16'd4, 16'd3, 1'b1, 1'b1, 1'b1, 8'd7, 1'b0, 1'b0},  // R6 after window
    '{16'd4, 16'd3, 1'b0, 1'b0, 1'b1, 8'd5, 1'b1, 1'b1},  // R7 bypass inside window
    '{16'd4, 16'd3, 1'b0, 1'b1, 1'b0, 8'd5, 1'b0, 1'b1},  // R8 raw sync source
    '{16'd0, 16'd2, 1'b0, 1'b1, 1'b1, 8'd1, 1'b0, 1'b0},  // R4 zero offset
    '{16'd0, 16'd2, 1'b0, 1'b1, 1'b1, 8'd2, 1'b1, 1'b1},  // R4 zero offset, after
    '{16'd3, 16'd0, 1'b1, 1'b1, 1'b1, 8'd3, 1'b0, 1'b0},  // R10 inverted, no window
    '{16'd3, 16'd0, 1'b0, 1'b1, 1'b1, 8'd3, 1'b1, 1'b1}   // R10 normal, no window
  };

  // Strobe sampled at edge E; event placed in cycle n after E (n >= 1)
  task automatic runVec(input vec_t v, input int idx);
    cfgOffset = v.off; cfgWidth = v.wid; cfgInvert = v.inv;
    cfgBlankEn = v.en; cfgSyncFilt = v.src;
    @(negedge clk);
    zeroStrobe = 1'b1;
    if (v.n == 8'd1) trigIn = 1'b1;
    for (int i = 1; i <= int'(v.n) + 1; i++) begin
      @(negedge clk);
      if (i == 1) zeroStrobe = 1'b0;
      if (i == int'(v.n) - 1) trigIn = 1'b1;
    end
    check($sformatf("R2 vec%0d rawEvt", idx), rawEvt, 1'b1);
    check($sformatf("R4-vec%0d filtEvt", idx), filtEvt, v.eFilt);
    check($sformatf("R8 vec%0d syncEvt", idx), syncEvt, v.eSync);
    trigIn = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int pulses;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 rawEvt in reset", rawEvt, 1'b0);
    check("R1 filtEvt in reset", filtEvt, 1'b0);
    check("R1 syncEvt in reset", syncEvt, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rawEvt after reset", rawEvt, 1'b0);
    check("R1 syncEvt after reset", syncEvt, 1'b0);

    // vector table
    for (int k = 0; k < NV; k++) runVec(VECS[k], k);

    // R2: latency through synchroniser and edge register
    cfgBlankEn = 1'b0; cfgSyncFilt = 1'b0;
    @(negedge clk); trigIn = 1'b1;
    @(negedge clk); check("R2 no event one cycle after", rawEvt, 1'b0);
    @(negedge clk); check("R2 event two cycles after", rawEvt, 1'b1);
    @(negedge clk); check("R2 event cleared", rawEvt, 1'b0);

    // R3: long high gives one pulse, falling edge none
    trigIn = 1'b0;
    repeat (5) @(negedge clk);
    pulses = 0;
    trigIn = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (rawEvt) pulses++;
    end
    check("R3 single pulse on long high", pulses == 1, 1'b1);
    pulses = 0;
    trigIn = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (rawEvt) pulses++;
    end
    check("R3 no pulse on falling edge", pulses == 0, 1'b1);

    // R9: second strobe mid-offset restarts the count
    cfgOffset = 16'd4; cfgWidth = 16'd3; cfgInvert = 1'b0;
    cfgBlankEn = 1'b1; cfgSyncFilt = 1'b1;
    @(negedge clk); zeroStrobe = 1'b1;
    @(negedge clk); zeroStrobe = 1'b0;
    @(negedge clk);
    @(negedge clk); zeroStrobe = 1'b1; trigIn = 1'b1;
    @(negedge clk); zeroStrobe = 1'b0;
    @(negedge clk);
    check("R9 raw event present", rawEvt, 1'b1);
    check("R9 restarted window passes event", filtEvt, 1'b1);
    trigIn = 1'b0;
    repeat (5) @(negedge clk);

    // R5: spurious second edge blanked when it lands in the window
    cfgOffset = 16'd20; cfgWidth = 16'd10;
    @(negedge clk); zeroStrobe = 1'b1;
    @(negedge clk); zeroStrobe = 1'b0;
    repeat (23) @(negedge clk);
    trigIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R5 second edge raw", rawEvt, 1'b1);
    check("R5 second edge blanked", syncEvt, 1'b0);
    trigIn = 1'b0;
    repeat (3) @(negedge clk);

    summary();
    $finish;
  end

endmodule